// File: doc/BRIEF.md
# Flow-Through Synchronous SRAM with Pipelined Writes

This block is a small synthesizable model of a flow-through synchronous SRAM that needs no idle cycle between a write and a read. Every control input is registered on the rising clock edge. These inputs are the address, three chip selects, the write strobe, the load/advance control and four per-lane write masks. Read data leaves the array combinationally once the address has been registered. Write data arrives on the cycle after its address and is committed on the edge that closes that cycle.

The block serves as a memory target in a verification environment, or as a reference for a controller that drives this style of part. A load cycle starts an access, and later advance cycles step a 2-bit burst counter through a linearly wrapping four-beat block. A clock-enable input freezes the whole device. A sleep input forces it into a deselected state, and output enable gates the data drivers without any clock.

Top module: `ft_sram`

## Requirements
- R1: After reset the device is deselected, `rdata_oe` is 0, and every word of the array reads as zero.
- R2: A selected load with `we_n`=1 drives `mem[addr]` on `rdata` in the cycle that follows the registering edge, with no further edge needed, as long as `oe_n` is 0.
- R3: A selected load with `we_n`=0 commits `wdata` on the next enabled edge. For each lane i, bits [8i+7:8i] are written only when `lane_wr_n[i]` is 0. The mask is sampled together with each address beat, on both load and advance cycles.
- R4: When `load_n` is 1 the two low address bits advance by one and wrap modulo 4, while the upper bits stay fixed. `we_n` is ignored on these cycles, so the burst keeps the direction it was loaded with.
- R5: A load is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. A deselected load writes nothing, drives nothing and ends any burst in progress. Advance cycles that follow keep the device idle.
- R6: A read that is loaded on the same edge that commits a write to the same address returns the newly written data.
- R7: `rdata_oe` is 1, and `rdata` is driven, exactly when a selected read is active, `oe_n` is 0 and `sleep` is 0. `oe_n` acts without a clock and changes no state. At all other times `rdata` is high impedance.
- R8: While `clk_en_n` is 1, clock edges are ignored. Address, burst state and any pending write are all held.
- R9: While `sleep` is 1, the drivers turn off at once, no pending write is committed, and each enabled edge deselects the device. Once `sleep` returns to 0, the device stays idle until the next selected load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en_n | input | 1 | Clock enable, active low |
| sleep | input | 1 | Low-power deselect, active high |
| load_n | input | 1 | 0 loads a new address, 1 advances the burst |
| we_n | input | 1 | Write strobe on load cycles, active low |
| addr | input | ADDR_W | Word address |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| lane_wr_n | input | LANES | Per-lane write masks, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | LANES*LANE_W | Write data, one cycle after its address |
| rdata | output | LANES*LANE_W | Read data, high impedance when not driven |
| rdata_oe | output | 1 | High while `rdata` is driven |

## Verification
The bench compares the device against a behavioural model on every cycle under several traffic types. Single writes followed by reads separate a correct commit edge from an early or late one. Partial lane masks show whether each mask bit is tied to the right byte. Four-beat bursts that start mid-block show whether the counter wraps or carries into the upper bits. Back-to-back write-then-read to one address exposes a stale read, and a random phase mixes selects, clock-enable stalls, sleep and output-enable changes to find interactions between them.

// File: rtl/ft_sram.sv
module ft_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clk_en_n,
  input  logic                      sleep,
  input  logic                      load_n,
  input  logic                      we_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      sel_a_n,
  input  logic                      sel_b,
  input  logic                      sel_c_n,
  input  logic [LANES-1:0]          lane_wr_n,
  input  logic                      oe_n,
  input  logic [LANES*LANE_W-1:0]   wdata,
  output logic [LANES*LANE_W-1:0]   rdata,
  output logic                      rdata_oe
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              act_vld, act_wr;
  logic [ADDR_W-1:0] act_addr;
  logic [LANES-1:0]  act_lane_n;

  wire edge_en = !clk_en_n;
  wire sel_ok  = !sel_a_n && sel_b && !sel_c_n;
  wire commit  = edge_en && !sleep && act_vld && act_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (commit) begin
      for (int l = 0; l < LANES; l++)
        if (!act_lane_n[l]) mem[act_addr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_vld    <= 1'b0;
      act_wr     <= 1'b0;
      act_addr   <= '0;
      act_lane_n <= '1;
    end else if (edge_en) begin
      if (sleep) begin
        act_vld <= 1'b0;
      end else if (!load_n) begin
        act_vld    <= sel_ok;
        act_wr     <= !we_n;
        act_addr   <= addr;
        act_lane_n <= lane_wr_n;
      end else if (act_vld) begin
        act_addr   <= {act_addr[ADDR_W-1:2], act_addr[1:0] + 2'd1};
        act_lane_n <= lane_wr_n;
      end
    end
  end

  assign rdata_oe = act_vld && !act_wr && !oe_n && !sleep;
  assign rdata    = rdata_oe ? mem[act_addr] : 'z;

  // R8
  cke_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> $stable(act_addr) && $stable(act_vld) && $stable(act_wr));

  // R4
  burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !sleep && load_n && act_vld) |=>
      (act_addr[1:0] == $past(act_addr[1:0]) + 2'd1) &&
      (act_addr[ADDR_W-1:2] == $past(act_addr[ADDR_W-1:2])) && (act_wr == $past(act_wr)));

  // R9
  sleep_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && sleep) |=> !act_vld && !rdata_oe);

  // R5
  desel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !sleep && !load_n && (sel_a_n || !sel_b || sel_c_n)) |=> !act_vld);

  // R5
  idle_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && load_n && !act_vld) |=> !act_vld);
endmodule

// File: tb/tb_ft_sram.sv
module tb_ft_sram;
  logic clk = 0, rst_n = 0, clk_en_n = 0, sleep = 0, load_n = 0, we_n = 1;
  logic [5:0] addr = 0;
  logic sel_a_n = 0, sel_b = 0, sel_c_n = 0, oe_n = 0;
  logic [3:0] lane_wr_n = 4'hF;
  logic [31:0] wdata = 0;
  wire  [31:0] rdata;
  wire         rdata_oe;

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_req = "R1";

  ft_sram dut (.clk, .rst_n, .clk_en_n, .sleep, .load_n, .we_n, .addr, .sel_a_n,
               .sel_b, .sel_c_n, .lane_wr_n, .oe_n, .wdata, .rdata, .rdata_oe);

  always #4 clk = ~clk;

  logic [31:0] mm [64];
  bit mv, mw;
  int ma;
  logic [3:0] mb;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (mm[i]) mm[i] = 0;
      mv = 0; mw = 0; ma = 0; mb = 4'hF;
    end else if (!clk_en_n) begin
      if (!sleep && mv && mw)
        for (int b = 0; b < 4; b++) if (!mb[b]) mm[ma][8*b +: 8] = wdata[8*b +: 8];
      if (sleep) mv = 0;
      else if (!load_n) begin
        mv = !sel_a_n && sel_b && !sel_c_n; mw = !we_n; ma = int'(addr); mb = lane_wr_n;
      end else if (mv) begin
        ma = (ma & ~3) | ((ma + 1) & 3); mb = lane_wr_n;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    automatic bit eo = mv && !mw && !oe_n && !sleep;
    chk(rdata_oe === eo, cur_req, {31'd0, rdata_oe}, {31'd0, eo});
    if (eo) chk(rdata === mm[ma], cur_req, rdata, mm[ma]);
  end

  task automatic tick(); @(negedge clk); #1; endtask
  task automatic idle(); load_n = 0; sel_a_n = 0; sel_b = 0; sel_c_n = 0; we_n = 1; lane_wr_n = 4'hF; endtask
  task automatic ld(input bit wr, input int a, input logic [3:0] ln);
    load_n = 0; sel_a_n = 0; sel_b = 1; sel_c_n = 0; we_n = !wr; addr = a[5:0]; lane_wr_n = ln;
  endtask
  task automatic adv(input logic [3:0] ln); load_n = 1; we_n = ~we_n; lane_wr_n = ln; addr = ~addr; endtask
  task automatic wr1(input int a, input logic [3:0] ln, input logic [31:0] d);
    ld(1, a, ln); tick(); wdata = d; idle(); tick();
  endtask
  task automatic rd_chk(input int a, input logic [31:0] exp, input string tag);
    ld(0, a, 4'hF); tick(); chk(rdata_oe === 1'b1 && rdata === exp, tag, rdata, exp); idle();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      summary(); $finish;
    end
  end

  initial begin
    idle();
    repeat (3) tick();
    rst_n = 1; tick();
    chk(rdata_oe === 1'b0, "R1 drivers off", {31'd0, rdata_oe}, 0);
    rd_chk(5, 32'h0, "R1 array cleared");
    tick();

    cur_req = "R2";
    wr1(8, 4'h0, 32'hA1B2C3D4);
    rd_chk(8, 32'hA1B2C3D4, "R2 flow-through read");
    tick();

    cur_req = "R3";
    wr1(32, 4'h0, 32'hFFFFFFFF);
    wr1(32, 4'b1010, 32'h11223344);
    rd_chk(32, 32'hFF22FF44, "R3 lane mask");
    tick();

    cur_req = "R4";
    ld(1, 18, 4'h0); tick();
    wdata = 32'h0000AAA0; adv(4'h0); tick();
    wdata = 32'h0000AAA1; adv(4'h0); tick();
    wdata = 32'h0000AAA2; adv(4'hE); tick();
    wdata = 32'hFFFFAAA3; idle(); tick();
    ld(0, 17, 4'hF); tick();
    chk(rdata === 32'h000000A3, "R4 beat0 addr 17", rdata, 32'h000000A3);
    adv(4'hF); tick();
    chk(rdata === 32'h0000AAA0, "R4 beat1 addr 18", rdata, 32'h0000AAA0);
    adv(4'hF); tick();
    chk(rdata === 32'h0000AAA1, "R4 beat2 addr 19", rdata, 32'h0000AAA1);
    adv(4'hF); tick();
    chk(rdata === 32'h0000AAA2, "R4 wrap to addr 16", rdata, 32'h0000AAA2);
    idle(); tick();

    cur_req = "R6";
    ld(1, 48, 4'h0); tick();
    wdata = 32'hCAFEF00D; ld(0, 48, 4'hF); tick();
    chk(rdata === 32'hCAFEF00D, "R6 write then read", rdata, 32'hCAFEF00D);
    idle(); tick();

    cur_req = "R5";
    ld(1, 8, 4'h0); sel_a_n = 1; tick();
    wdata = 32'hDEADBEEF; idle(); tick();
    rd_chk(8, 32'hA1B2C3D4, "R5 deselected write ignored");
    ld(0, 16, 4'hF); sel_b = 0; tick();
    chk(rdata_oe === 1'b0, "R5 deselected read", {31'd0, rdata_oe}, 0);
    ld(0, 16, 4'hF); tick();
    ld(0, 16, 4'hF); sel_c_n = 1; tick();
    chk(rdata_oe === 1'b0, "R5 burst ended", {31'd0, rdata_oe}, 0);
    adv(4'hF); tick();
    chk(rdata_oe === 1'b0, "R5 advance while idle", {31'd0, rdata_oe}, 0);
    idle(); tick();

    cur_req = "R7";
    ld(0, 8, 4'hF); tick();
    oe_n = 1; #1;
    chk(rdata_oe === 1'b0, "R7 oe off async", {31'd0, rdata_oe}, 0);
    oe_n = 0; #1;
    chk(rdata_oe === 1'b1 && rdata === 32'hA1B2C3D4, "R7 oe on async", rdata, 32'hA1B2C3D4);
    idle(); tick();

    cur_req = "R8";
    ld(1, 40, 4'h0); tick();
    wdata = 32'h11111111; clk_en_n = 1; idle(); tick();
    wdata = 32'h22222222; clk_en_n = 0; ld(0, 40, 4'hF); tick();
    chk(rdata === 32'h22222222, "R8 stalled write held", rdata, 32'h22222222);
    clk_en_n = 1; idle(); tick();
    chk(rdata_oe === 1'b1 && rdata === 32'h22222222, "R8 read held", rdata, 32'h22222222);
    clk_en_n = 0; idle(); tick();

    cur_req = "R9";
    ld(1, 8, 4'h0); tick();
    wdata = 32'h0BAD0BAD; sleep = 1; idle(); tick();
    chk(rdata_oe === 1'b0, "R9 asleep", {31'd0, rdata_oe}, 0);
    sleep = 0; adv(4'h0); tick();
    rd_chk(8, 32'hA1B2C3D4, "R9 write dropped");
    sleep = 1; #1;
    chk(rdata_oe === 1'b0, "R9 drivers off async", {31'd0, rdata_oe}, 0);
    sleep = 0; idle(); tick();

    cur_req = "R3 random";
    for (int n = 0; n < 400; n++) begin
      automatic int r = $urandom_range(0, 9);
      wdata = $urandom;
      oe_n = ($urandom_range(0, 7) == 0);
      clk_en_n = ($urandom_range(0, 7) == 0);
      sleep = ($urandom_range(0, 15) == 0);
      if (r < 5) begin
        ld($urandom_range(0, 1), $urandom_range(0, 63), 4'($urandom));
        if ($urandom_range(0, 5) == 0) sel_b = 0;
      end else adv(4'($urandom));
      tick();
    end
    clk_en_n = 0; sleep = 0; oe_n = 0; idle(); tick();

    done = 1;
    summary();
    $finish;
  end
endmodule